// File: doc/BRIEF.md
# Test-Mode Reset Controller

This block produces a chip's internal system reset from two sources: an asynchronous hardware reset pin, and a PLL lock indication that counts only after it has been held steady for a long settling time (50 ms by default, set by a clock-cycles-per-millisecond parameter and a millisecond count). Any loss of lock restarts the settling count and puts the chip back into reset.

The block also controls a board-level digital test mode. The mode can only be entered while a multi-function enable pin is high. Entry happens in one of two ways: the pin is sampled once when the hardware reset is released, or software writes a key value to a configuration register. Writing any other value leaves the mode. While the mode is active, the lock input no longer acts as a reset source. A dedicated pin drives an active-high reset for the real-time clock, and the same reset also holds the watchdog disabled. A flag tells the clock logic to take the chip clock from a test pin. All asynchronous pins pass through two-flop synchronisers before use.

Top module: `test_reset_ctrl`

## Requirements
- R1: While `hwRstN` is low, `sysRst` is 1 and `testMode`, `clkSelTest` and `rtcRst` are 0. They take these values as soon as `hwRstN` falls, without waiting for a clock.
- R2: The mode is off and `pllLock` is raised and then held. Let T = CYC_PER_MS*LOCK_MS. `sysRst` stays 1 through rising edge T+2 and drops to 0 on edge T+3. Edge 1 is the first edge that samples the new `pllLock` level.
- R3: The mode is off and `pllLock` falls. `sysRst` is still 0 after the 3rd rising edge and is 1 after the 4th. A low lasting one clock clears the settling count, so the full T+3 wait applies again from the next rise.
- R4: `mfEnable` is high when `hwRstN` is released. `testMode` is 0 after the 2nd rising edge and 1 after the 3rd. `sysRst` is 0 after the 4th even with `pllLock` low. If `mfEnable` is low at release, `testMode` stays 0.
- R5: A write (`cfgWrEn`=1) of `cfgWrData`==TEST_KEY (default 16'hA5A5) while the synchronised `mfEnable` is high sets `testMode` on the edge that samples the write.
- R6: A TEST_KEY write while the synchronised `mfEnable` is low leaves `testMode` unchanged.
- R7: A write of any value other than TEST_KEY clears `testMode` on the edge that samples it.
- R8: While the mode is on, `rtcRst` follows `rtcRstPin` three rising edges later, and the same reset holds the watchdog disabled. While the mode is off, `rtcRst` is 0 whatever the pin does.
- R9: `clkSelTest` always equals `testMode`.
- R10: While the mode is on, `sysRst` is 0 whatever `pllLock` does.
- R11: Once the mode is on, only a write or a hardware reset changes it. `mfEnable` going low does not leave the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hwRstN | input | 1 | Asynchronous hardware reset, active low |
| pllLock | input | 1 | PLL lock indication, asynchronous |
| mfEnable | input | 1 | Multi-function pin that permits test-mode entry, asynchronous |
| cfgWrEn | input | 1 | Configuration register write strobe, synchronous |
| cfgWrData | input | DATA_W | Configuration register write data |
| rtcRstPin | input | 1 | Test-mode RTC reset pin, active high, asynchronous |
| sysRst | output | 1 | Internal system reset, active high |
| rtcRst | output | 1 | RTC reset and watchdog hold, active high |
| testMode | output | 1 | Test mode active |
| clkSelTest | output | 1 | Selects the test pin as the chip clock |

## Verification
The lock delay is tried with three patterns. A clean rise tells T+2 from T+3 at the exact edge. A held-then-dropped lock checks the four-edge return to reset. A one-clock dropout in the middle of the count shows whether the count truly restarts or only pauses. Test mode is stressed by random toggling of lock, the enable pin and the RTC pin, which separates a lock input that is really bypassed from one that merely happens to be stable, and checks the three-edge RTC pin path against a delayed copy kept in the bench. Random configuration writes, with the enable pin sometimes low, separate the key-with-pin, key-without-pin and other-value cases. A second hardware reset with the pin high covers entry at boot.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // indexes of the asynchronous pins inside the synchroniser bank
  localparam int IDX_LOCK = 0;
  localparam int IDX_MF   = 1;
  localparam int IDX_RTC  = 2;
  localparam int N_ASYNC  = 3;

  // strobes from control into datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } dpCtrl_t;

  // status from datapath back to control
  typedef struct packed {
    logic hwRstInt;
    logic lockSync;
    logic mfSync;
    logic rtcPinSync;
    logic cntDone;
  } dpStat_t;

  typedef enum logic [0:0] {
    ST_BOOT = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/trc_sync.sv
module trc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_TARGET = 1000000,
  localparam int CNT_W = $clog2(LOCK_TARGET + 1)
) (
  input  logic    clk,
  input  logic    hwRstN,
  input  logic    pllLock,
  input  logic    mfEnable,
  input  logic    rtcRstPin,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);

  localparam logic [CNT_W-1:0] TGT = CNT_W'(LOCK_TARGET);

  logic               hwRstInt;
  logic [N_ASYNC-1:0] asyncIn;
  logic [N_ASYNC-1:0] syncOut;
  logic [CNT_W-1:0]   lockCnt;

  // reset: asynchronous assert, synchronised release
  trc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rstSync (
    .clk (clk),
    .rstN(hwRstN),
    .d   (1'b0),
    .q   (hwRstInt)
  );

  assign asyncIn[IDX_LOCK] = pllLock;
  assign asyncIn[IDX_MF]   = mfEnable;
  assign asyncIn[IDX_RTC]  = rtcRstPin;

  for (genvar i = 0; i < N_ASYNC; i++) begin : g_pinSync
    trc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk (clk),
      .rstN(hwRstN),
      .d   (asyncIn[i]),
      .q   (syncOut[i])
    );
  end

  // lock settling counter, saturating at the target
  always_ff @(posedge clk or posedge hwRstInt) begin
    if (hwRstInt) begin
      lockCnt <= '0;
    end else if (ctrl.cntClear) begin
      lockCnt <= '0;
    end else if (ctrl.cntInc) begin
      lockCnt <= lockCnt + 1'b1;
    end
  end

  assign stat.hwRstInt   = hwRstInt;
  assign stat.lockSync   = syncOut[IDX_LOCK];
  assign stat.mfSync     = syncOut[IDX_MF];
  assign stat.rtcPinSync = syncOut[IDX_RTC];
  assign stat.cntDone    = (lockCnt == TGT);

endmodule

// File: rtl/trc_control.sv
module trc_control
  import trc_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] TEST_KEY = 16'hA5A5
) (
  input  logic              clk,
  input  dpStat_t           stat,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output dpCtrl_t           ctrl,
  output logic              sysRst,
  output logic              rtcRst,
  output logic              testMode,
  output logic              clkSelTest
);

  ctrlState_t state;
  logic       modeNext;

  // counter strobes: clear on any loss of lock, count up until done
  assign ctrl.cntClear = !stat.lockSync;
  assign ctrl.cntInc   = stat.lockSync && !stat.cntDone;

  // mode decision: a write wins over the one-time boot sample
  always_comb begin
    modeNext = testMode;
    if (cfgWrEn) begin
      if (cfgWrData == TEST_KEY) begin
        if (stat.mfSync) begin
          modeNext = 1'b1;
        end
      end else begin
        modeNext = 1'b0;
      end
    end else if (state == ST_BOOT) begin
      modeNext = stat.mfSync;
    end
  end

  always_ff @(posedge clk or posedge stat.hwRstInt) begin
    if (stat.hwRstInt) begin
      state      <= ST_BOOT;
      testMode   <= 1'b0;
      clkSelTest <= 1'b0;
    end else begin
      state      <= ST_RUN;
      testMode   <= modeNext;
      clkSelTest <= modeNext;
    end
  end

  // reset outputs, registered
  always_ff @(posedge clk or posedge stat.hwRstInt) begin
    if (stat.hwRstInt) begin
      sysRst <= 1'b1;
      rtcRst <= 1'b0;
    end else begin
      sysRst <= !testMode && !stat.cntDone;
      rtcRst <= testMode && stat.rtcPinSync;
    end
  end

endmodule

// File: rtl/test_reset_ctrl.sv
module test_reset_ctrl
  import trc_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter logic [DATA_W-1:0] TEST_KEY    = 16'hA5A5,
  parameter int                CYC_PER_MS  = 20000,
  parameter int                LOCK_MS     = 50,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              pllLock,
  input  logic              mfEnable,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              rtcRstPin,
  output logic              sysRst,
  output logic              rtcRst,
  output logic              testMode,
  output logic              clkSelTest
);

  localparam int LOCK_TARGET = CYC_PER_MS * LOCK_MS;

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  trc_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .LOCK_TARGET(LOCK_TARGET)
  ) u_dp (
    .clk      (clk),
    .hwRstN   (hwRstN),
    .pllLock  (pllLock),
    .mfEnable (mfEnable),
    .rtcRstPin(rtcRstPin),
    .ctrl     (dpCtrl),
    .stat     (dpStat)
  );

  trc_control #(
    .DATA_W  (DATA_W),
    .TEST_KEY(TEST_KEY)
  ) u_ctrl (
    .clk       (clk),
    .stat      (dpStat),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .ctrl      (dpCtrl),
    .sysRst    (sysRst),
    .rtcRst    (rtcRst),
    .testMode  (testMode),
    .clkSelTest(clkSelTest)
  );

endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] TEST_KEY = 16'hA5A5,
  parameter int                TARGET   = 1000000
) (
  input logic              clk,
  input logic              hwRstN,
  input logic              hwRstInt,
  input logic              lockSync,
  input logic              mfSync,
  input logic              rtcPinSync,
  input logic              cntDone,
  input logic              cfgWrEn,
  input logic [DATA_W-1:0] cfgWrData,
  input logic              sysRst,
  input logic              rtcRst,
  input logic              testMode,
  input logic              clkSelTest
);

  // independent count of cycles the synchronised lock has stayed high
  int chkRun;
  always_ff @(posedge clk or posedge hwRstInt) begin
    if (hwRstInt) begin
      chkRun <= 0;
    end else if (!lockSync) begin
      chkRun <= 0;
    end else if (chkRun <= TARGET) begin
      chkRun <= chkRun + 1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !hwRstN |-> (sysRst && !testMode && !rtcRst && !clkSelTest));

  p_lock_window_r2: assert property (@(posedge clk) disable iff (hwRstInt)
    (!sysRst && !$past(testMode)) |-> ($past(chkRun) >= TARGET));

  p_restart_r3: assert property (@(posedge clk) disable iff (hwRstInt)
    !lockSync |=> !cntDone);

  p_key_enter_r5: assert property (@(posedge clk) disable iff (hwRstInt)
    (cfgWrEn && cfgWrData == TEST_KEY && mfSync) |=> testMode);

  p_pin_gate_r6: assert property (@(posedge clk) disable iff (hwRstInt)
    (cfgWrEn && !mfSync && !testMode) |=> !testMode);

  p_other_clear_r7: assert property (@(posedge clk) disable iff (hwRstInt)
    (cfgWrEn && cfgWrData != TEST_KEY) |=> !testMode);

  p_rtc_idle_r8: assert property (@(posedge clk) disable iff (hwRstInt)
    !$past(testMode) |-> !rtcRst);

  p_rtc_follow_r8: assert property (@(posedge clk) disable iff (hwRstInt)
    $past(testMode) |-> (rtcRst == $past(rtcPinSync)));

  p_clk_sel_r9: assert property (@(posedge clk) disable iff (hwRstInt)
    clkSelTest == testMode);

  p_bypass_r10: assert property (@(posedge clk) disable iff (hwRstInt)
    $past(testMode) |-> !sysRst);

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (hwRstInt)
    (testMode && !cfgWrEn) |=> testMode);

endmodule

bind test_reset_ctrl trc_checker #(
  .DATA_W  (DATA_W),
  .TEST_KEY(TEST_KEY),
  .TARGET  (LOCK_TARGET)
) u_chk (
  .clk       (clk),
  .hwRstN    (hwRstN),
  .hwRstInt  (dpStat.hwRstInt),
  .lockSync  (dpStat.lockSync),
  .mfSync    (dpStat.mfSync),
  .rtcPinSync(dpStat.rtcPinSync),
  .cntDone   (dpStat.cntDone),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .sysRst    (sysRst),
  .rtcRst    (rtcRst),
  .testMode  (testMode),
  .clkSelTest(clkSelTest)
);

// File: tb/tb_test_reset_ctrl.sv
module tb_test_reset_ctrl;

  localparam int          CLK_PERIOD = 10;
  localparam int          CPM        = 4;
  localparam int          LMS        = 5;
  localparam int          T          = CPM * LMS;
  localparam logic [15:0] KEY        = 16'hA5A5;

  logic        clk = 1'b0;
  logic        hwRstN = 1'b1;
  logic        pllLock = 1'b0;
  logic        mfEnable = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        rtcRstPin = 1'b0;
  logic        sysRst, rtcRst, testMode, clkSelTest;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  test_reset_ctrl #(
    .DATA_W(16), .TEST_KEY(KEY), .CYC_PER_MS(CPM), .LOCK_MS(LMS), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .hwRstN(hwRstN), .pllLock(pllLock), .mfEnable(mfEnable),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .rtcRstPin(rtcRstPin),
    .sysRst(sysRst), .rtcRst(rtcRst), .testMode(testMode), .clkSelTest(clkSelTest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // expected mode after a configuration write
  function automatic logic expMode(logic cur, logic [15:0] d, logic mf);
    if (d == KEY) return mf ? 1'b1 : cur;
    return 1'b0;
  endfunction

  function automatic logic expRtc(logic tm, logic pin);
    return tm & pin;
  endfunction

  task automatic cfgWrite(logic [15:0] d);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [2:0] hist;
    logic       m;
    logic       mf;
    logic [15:0] d;
    int unsigned seed;
    seed = $urandom(32'h5EED1234);

    // R1 reset state
    #1 hwRstN = 1'b0;
    rtcRstPin = 1'b1;
    tick(3);
    check("R1", "sysRst", sysRst, 1);
    check("R1", "testMode", testMode, 0);
    check("R1", "rtcRst", rtcRst, 0);
    check("R1", "clkSelTest", clkSelTest, 0);

    // release with enable pin low: no test mode
    rtcRstPin = 1'b0;
    hwRstN = 1'b1;
    tick(6);
    check("R4", "testMode pin low", testMode, 0);
    check("R2", "sysRst no lock", sysRst, 1);

    // R2 exact settling edge
    pllLock = 1'b1;
    tick(T + 2);
    check("R2", "sysRst at T+2", sysRst, 1);
    tick(1);
    check("R2", "sysRst at T+3", sysRst, 0);

    // R3 lock loss
    pllLock = 1'b0;
    tick(3);
    check("R3", "sysRst 3 edges after loss", sysRst, 0);
    tick(1);
    check("R3", "sysRst 4 edges after loss", sysRst, 1);

    // R3 restart after one-clock dropout
    pllLock = 1'b1;
    tick(10);
    pllLock = 1'b0;
    tick(1);
    pllLock = 1'b1;
    tick(T + 2);
    check("R3", "sysRst at T+2 after restart", sysRst, 1);
    tick(1);
    check("R3", "sysRst at T+3 after restart", sysRst, 0);

    // R8 pin ignored outside test mode
    rtcRstPin = 1'b1;
    tick(4);
    check("R8", "rtcRst outside mode", rtcRst, 0);
    rtcRstPin = 1'b0;

    // R6 key with pin low
    mfEnable = 1'b0;
    tick(3);
    cfgWrite(KEY);
    check("R6", "testMode key pin low", testMode, 0);
    tick(1);
    check("R6", "sysRst key pin low", sysRst, 0);

    // R5 key with pin high
    mfEnable = 1'b1;
    tick(3);
    cfgWrite(KEY);
    check("R5", "testMode key pin high", testMode, 1);
    check("R9", "clkSelTest on entry", clkSelTest, 1);
    tick(3);

    // R10, R8, R11 random stimulus inside test mode
    hist = '0;
    for (int i = 0; i < 300; i++) begin
      logic p;
      check("R10", "sysRst in mode", sysRst, 0);
      check("R11", "testMode held", testMode, 1);
      check("R8", "rtcRst follows pin", rtcRst, expRtc(1'b1, hist[2]));
      check("R9", "clkSelTest in mode", clkSelTest, 1);
      pllLock  = 1'($urandom % 2);
      mfEnable = 1'($urandom % 2);
      p = 1'($urandom % 2);
      rtcRstPin = p;
      hist = {hist[1:0], p};
      tick(1);
    end

    // R7 other value clears
    pllLock = 1'b0;
    rtcRstPin = 1'b0;
    mfEnable = 1'b1;
    tick(3);
    cfgWrite(KEY ^ 16'h0001);
    check("R7", "testMode after other value", testMode, 0);
    check("R9", "clkSelTest after exit", clkSelTest, 0);
    tick(1);
    check("R7", "sysRst after exit", sysRst, 1);

    // random writes against the model
    m = 1'b0;
    for (int i = 0; i < 40; i++) begin
      mf = 1'($urandom % 2);
      mfEnable = mf;
      tick(3);
      d = ($urandom % 2) ? KEY : 16'($urandom);
      cfgWrite(d);
      m = expMode(m, d, mf);
      if (d != KEY)      check("R7", "testMode random write", testMode, m);
      else if (mf)       check("R5", "testMode random write", testMode, m);
      else               check("R6", "testMode random write", testMode, m);
      check("R9", "clkSelTest random write", clkSelTest, m);
    end

    // R4 boot entry with pin high, R1 mid-run reset
    mfEnable = 1'b1;
    pllLock = 1'b0;
    hwRstN = 1'b0;
    tick(2);
    check("R1", "sysRst mid-run reset", sysRst, 1);
    check("R1", "testMode mid-run reset", testMode, 0);
    hwRstN = 1'b1;
    tick(2);
    check("R4", "testMode 2 edges after release", testMode, 0);
    tick(1);
    check("R4", "testMode 3 edges after release", testMode, 1);
    tick(1);
    check("R4", "sysRst without lock", sysRst, 0);

    // R11 pin low does not exit
    mfEnable = 1'b0;
    tick(5);
    check("R11", "testMode after pin low", testMode, 1);

    finishRun();
  end

endmodule